// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes a received frame as a stream of bytes, one beat per cycle, marked with start and end flags. It places the frame into one page of a paged packet RAM in a fixed stored image. The image holds a little-endian status word and a little-endian byte count at the top of the page, then the payload. Frames shorter than 64 bytes are zero-padded. An optional CRC-32 follows the data on a 16-bit boundary. A trailing pair of bytes closes the image: a control byte plus, for odd frames, the odd last data byte.

When the start beat arrives, the writer checks the receive controls and whether the allocator offers a free page. If the frame is accepted, it claims that page and streams payload bytes into it as they arrive. After the end beat it writes the padding, the CRC and the closing pair, then goes back to the top of the page to write the status word and byte count. A done pulse then carries the page number, so the surrounding logic can push the page onto the receive queue and raise the receive interrupt. A frame that cannot be stored produces a drop pulse instead. If a page had already been claimed for that frame, the drop pulse carries its number so the page can be freed.

Top module: `rx_frame_writer`

## Requirements
- R1: RAM writes go to address {page, offset}, with an 11-bit byte offset inside a 2048-byte page. Payload byte i is written at offset 4+i in the cycle it arrives. The status word goes to offsets 0 (low byte) and 1 (high byte). The byte count goes to offsets 2 (low) and 3 (high).
- R2: Let n be the frame length and E the stored data length, where E = 64 when n < 64 and E = n rounded down to even otherwise. The stored byte count is E + 6, plus 4 when the CRC is kept.
- R3: When n < 64, zero bytes are written at offsets 4+n through 67. An odd last byte stays at its payload position, and a one-byte frame (start and end on the same beat) is handled this way.
- R4: The CRC is kept when strip_crc is low at the start beat. It uses the reflected polynomial 0xEDB88320 with an all-ones initial value and a final inversion. It covers the padded data: all n bytes when n >= 64, or the 64 padded bytes when n < 64. It is written low byte first at offsets 4+E through 7+E.
- R5: The closing pair sits at offset 4+E, plus 4 when the CRC is kept. When n >= 64 and n is odd, the pair is the last data byte followed by 0x60. In every other case it is 0x00 followed by 0x40.
- R6: Status bit 11 (0x0800) is set when n > 1518. Status bit 12 (0x1000) is set when n is odd. All other status bits are zero.
- R7: A frame is refused at its start beat when rx_enable is low, soft_reset is high or page_valid is low. A refused frame makes no RAM write and no page_take, and frm_drop pulses one cycle after its end beat.
- R8: A frame whose byte count would exceed 2048 produces no done pulse. Payload bytes that would fall outside the page are not written. frm_drop pulses with frm_page set to the claimed page.
- R9: page_take is high during the start beat of an accepted frame. The header is written after the closing pair, and frm_done pulses with frm_page one cycle after the last header write. After reset all outputs are low.
- R10: Cycles with in_valid low write nothing and do not advance the frame. Beats that arrive while idle without in_sof are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enabled |
| soft_reset | input | 1 | Soft reset asserted; refuses frames |
| strip_crc | input | 1 | Do not store the CRC |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| page_valid | input | 1 | Allocator offers a free page |
| page_num | input | 2 | Offered page number |
| page_take | output | 1 | Offered page is claimed |
| wr_en | output | 1 | Page RAM write strobe |
| wr_addr | output | 13 | Page RAM byte address {page, offset} |
| wr_data | output | 8 | Page RAM write data |
| frm_done | output | 1 | Frame stored; push page to receive queue |
| frm_drop | output | 1 | Frame not stored |
| frm_page | output | 2 | Page of the finished or dropped frame |

## Verification
The start beat has to do two things in the same cycle: decide whether to accept the frame and claim a page, and write the first payload byte to the page just offered. A one-byte frame adds a third event to that cycle, because its start and end flags arrive together and the tail sequence must also be chosen then. The bench drives these beats against a behavioural model. The model turns each frame into an ordered list of expected RAM writes, and every write seen on any clock is compared with the head of that list. The outcome pulse, the claimed page and a drained list are judged after each frame, across short, boundary, overlong and refused frames.

// File: rtl/rx_frame_writer.sv
module rx_frame_writer #(
  parameter int PAGE_BYTES = 2048,
  parameter int PAGES      = 4,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  parameter int CNT_W      = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         rx_enable,
  input  logic                                         soft_reset,
  input  logic                                         strip_crc,
  input  logic                                         in_valid,
  input  logic                                         in_sof,
  input  logic                                         in_eof,
  input  logic [7:0]                                   in_data,
  input  logic                                         page_valid,
  input  logic [$clog2(PAGES)-1:0]                     page_num,
  output logic                                         page_take,
  output logic                                         wr_en,
  output logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0]  wr_addr,
  output logic [7:0]                                   wr_data,
  output logic                                         frm_done,
  output logic                                         frm_drop,
  output logic [$clog2(PAGES)-1:0]                     frm_page
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = $clog2(PAGES);
  localparam logic [CNT_W-1:0] MINL    = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAXL    = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] PAY_LIM = CNT_W'(PAGE_BYTES - 4);

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_DISC, S_PAD, S_CRC, S_PAIR, S_HDR} st_t;

  st_t              st;
  logic [OFF_W-1:0] k;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc_q;
  logic [PG_W-1:0]  page_q;
  logic             strip_q;
  logic [7:0]       last_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] even_len(input logic [CNT_W-1:0] n);
    return (n < MINL) ? MINL : {n[CNT_W-1:1], 1'b0};
  endfunction

  function automatic logic [CNT_W:0] stored(input logic [CNT_W-1:0] n, input logic keep);
    return {1'b0, even_len(n)} + (keep ? (CNT_W+1)'(10) : (CNT_W+1)'(6));
  endfunction

  wire start    = in_valid && in_sof && st == S_IDLE;
  wire ok_start = start && rx_enable && !soft_reset && page_valid;
  wire take     = ok_start || (st == S_RECV && in_valid);
  wire [CNT_W-1:0] n_nx = (st == S_IDLE) ? CNT_W'(1) : ((&cnt) ? cnt : cnt + CNT_W'(1));
  wire keep_nx  = (st == S_IDLE) ? !strip_crc : !strip_q;
  wire ovf_nx   = stored(n_nx, keep_nx) > (CNT_W+1)'(PAGE_BYTES);
  wire short_nx = n_nx < MINL;
  wire st_t tail_st = short_nx ? S_PAD : (keep_nx ? S_CRC : S_PAIR);
  wire [OFF_W-1:0] tail_k = short_nx ? OFF_W'(n_nx) : '0;

  wire             keep     = !strip_q;
  wire             odd_long = cnt[0] && cnt >= MINL;
  wire [OFF_W-1:0] e_off    = OFF_W'(even_len(cnt));
  wire [15:0]      status   = {3'b000, cnt[0], cnt > MAXL, 11'b0};
  wire [15:0]      count    = 16'(stored(cnt, keep));
  wire [31:0]      crc_sh   = ~crc_q >> {k[1:0], 3'b000};
  wire             pay_fit  = (st == S_IDLE) || (cnt < PAY_LIM);
  wire [OFF_W-1:0] pay_off  = (st == S_IDLE) ? OFF_W'(4) : OFF_W'(cnt) + OFF_W'(4);

  logic [OFF_W-1:0] off;
  assign page_take = ok_start;
  assign frm_page  = page_q;
  assign wr_addr   = {(st == S_IDLE) ? page_num : page_q, off};

  always_comb begin
    wr_en   = 1'b0;
    off     = '0;
    wr_data = 8'h00;
    case (st)
      S_IDLE, S_RECV: if (take && pay_fit) begin
        wr_en = 1'b1; off = pay_off; wr_data = in_data;
      end
      S_PAD: begin wr_en = 1'b1; off = OFF_W'(4) + k; end
      S_CRC: begin wr_en = 1'b1; off = OFF_W'(4) + e_off + k; wr_data = crc_sh[7:0]; end
      S_PAIR: begin
        wr_en = 1'b1;
        off = OFF_W'(4) + e_off + (keep ? OFF_W'(4) : OFF_W'(0)) + k;
        if (k == '0) wr_data = odd_long ? last_q : 8'h00;
        else         wr_data = odd_long ? 8'h60 : 8'h40;
      end
      S_HDR: begin
        wr_en = 1'b1; off = k;
        case (k[1:0])
          2'd0:    wr_data = status[7:0];
          2'd1:    wr_data = status[15:8];
          2'd2:    wr_data = count[7:0];
          default: wr_data = count[15:8];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; k <= '0; cnt <= '0; crc_q <= '0; page_q <= '0;
      strip_q <= 1'b0; last_q <= '0; frm_done <= 1'b0; frm_drop <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      frm_drop <= 1'b0;
      if (take) begin
        cnt    <= n_nx;
        last_q <= in_data;
        crc_q  <= crc_step((st == S_IDLE) ? 32'hFFFFFFFF : crc_q, in_data);
      end
      case (st)
        S_IDLE: if (ok_start) begin
          page_q  <= page_num;
          strip_q <= strip_crc;
          if (in_eof) begin st <= tail_st; k <= tail_k; end
          else st <= S_RECV;
        end else if (start) begin
          if (in_eof) frm_drop <= 1'b1;
          else st <= S_DISC;
        end
        S_RECV: if (in_valid && in_eof) begin
          if (ovf_nx) begin frm_drop <= 1'b1; st <= S_IDLE; end
          else begin st <= tail_st; k <= tail_k; end
        end
        S_DISC: if (in_valid && in_eof) begin frm_drop <= 1'b1; st <= S_IDLE; end
        S_PAD: begin
          crc_q <= crc_step(crc_q, 8'h00);
          k <= k + OFF_W'(1);
          if (k == OFF_W'(MIN_LEN - 1)) begin st <= keep ? S_CRC : S_PAIR; k <= '0; end
        end
        S_CRC: begin
          k <= k + OFF_W'(1);
          if (k == OFF_W'(3)) begin st <= S_PAIR; k <= '0; end
        end
        S_PAIR: begin
          k <= k + OFF_W'(1);
          if (k == OFF_W'(1)) begin st <= S_HDR; k <= '0; end
        end
        S_HDR: begin
          k <= k + OFF_W'(1);
          if (k == OFF_W'(3)) begin st <= S_IDLE; k <= '0; frm_done <= 1'b1; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    page_take |-> (rx_enable && !soft_reset && page_valid && in_valid && in_sof)); // R7
  AST_NO_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DISC) |-> !wr_en); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAD) |-> (wr_en && wr_data == 8'h00 && wr_addr[OFF_W-1:0] < OFF_W'(MIN_LEN + 4))); // R3
  AST_CTRL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAIR && k == OFF_W'(1)) |-> (wr_data == 8'h60 || wr_data == 8'h40)); // R5
  AST_DONE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> ($past(wr_en) && $past(wr_addr[OFF_W-1:0]) == OFF_W'(3))); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_done && frm_drop)); // R8
endmodule

// File: tb/test_rx_frame_writer.sv
`timescale 1ns/1ps
module test_rx_frame_writer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_enable = 0, soft_reset = 0, strip_crc = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic page_valid = 0;
  logic [1:0] page_num = 0;
  logic page_take, wr_en, frm_done, frm_drop;
  logic [12:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] frm_page;

  always #2.5 clk = ~clk;

  rx_frame_writer i_rx_frame_writer (.*);

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, drop_cnt = 0, take_cnt = 0, wr_total = 0;
  logic [1:0] out_pg = 0;
  int exp_a[$];
  logic [7:0] exp_d[$];
  logic [7:0] frm[$];
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      wr_total++;
      if (exp_a.size() == 0) chk(0, cur_tag, "unexpected write (addr)", wr_addr, -1);
      else begin
        int ea; logic [7:0] ed;
        ea = exp_a.pop_front(); ed = exp_d.pop_front();
        chk(wr_addr == 13'(ea) && wr_data == ed, cur_tag, "write {addr,data}",
            {wr_addr, wr_data}, {13'(ea), ed});
      end
    end
    if (page_take) take_cnt++;
    if (frm_done) begin done_cnt++; out_pg = frm_page; end
    if (frm_drop) begin drop_cnt++; out_pg = frm_page; end
  end

  function automatic logic [31:0] crc_ref(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = (i < frm.size()) ? frm[i] : 8'h00;
      c ^= {24'h0, b};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push(input int pg, input int off, input logic [7:0] d);
    exp_a.push_back(pg * 2048 + off);
    exp_d.push_back(d);
  endtask

  task automatic run_frame(input int n, input bit strip, input bit en, input bit srst,
                           input bit pv, input logic [1:0] pg, input bit gaps, input string tag);
    int e, cntv, d0, dr0, t0, t;
    bit acc, ovf, keep, oddl;
    logic [31:0] crc;
    logic [15:0] st;
    cur_tag = tag;
    frm.delete();
    for (int i = 0; i < n; i++) frm.push_back(8'((i * 37 + n * 11 + 5) ^ (i >> 3)));
    keep = !strip;
    acc  = en && !srst && pv;
    e    = (n < 64) ? 64 : (n & ~1);
    cntv = e + 6 + (keep ? 4 : 0);
    ovf  = cntv > 2048;
    oddl = (n >= 64) && (n % 2 == 1);
    if (acc) begin
      for (int i = 0; i < n; i++) if (4 + i < 2048) push(pg, 4 + i, frm[i]);
      if (!ovf) begin
        if (n < 64) for (int i = n; i < 64; i++) push(pg, 4 + i, 8'h00);
        if (keep) begin
          crc = crc_ref((n < 64) ? 64 : n);
          for (int i = 0; i < 4; i++) push(pg, 4 + e + i, 8'(crc >> (8 * i)));
        end
        push(pg, 4 + e + (keep ? 4 : 0), oddl ? frm[n-1] : 8'h00);
        push(pg, 5 + e + (keep ? 4 : 0), oddl ? 8'h60 : 8'h40);
        st = 16'((n % 2) << 12) | ((n > 1518) ? 16'h0800 : 16'h0000);
        push(pg, 0, st[7:0]);   push(pg, 1, st[15:8]);
        push(pg, 2, 8'(cntv));  push(pg, 3, 8'(cntv >> 8));
      end
    end
    d0 = done_cnt; dr0 = drop_cnt; t0 = take_cnt;
    @(posedge clk); #1;
    rx_enable = en; soft_reset = srst; strip_crc = strip; page_valid = pv; page_num = pg;
    for (int i = 0; i < n; i++) begin
      if (gaps && i % 4 == 2) begin @(posedge clk); #1; in_valid = 0; end
      @(posedge clk); #1;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = frm[i];
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0; page_valid = 0; page_num = ~pg;
    t = 0;
    while (done_cnt == d0 && drop_cnt == dr0 && t < 400) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt - d0 == int'(acc && !ovf), tag, "done pulses", done_cnt - d0, int'(acc && !ovf));
    chk(drop_cnt - dr0 == int'(!acc || ovf), tag, "drop pulses", drop_cnt - dr0, int'(!acc || ovf));
    chk(take_cnt - t0 == int'(acc), tag, "page_take pulses", take_cnt - t0, int'(acc));
    if (acc) chk(out_pg == pg, tag, "frm_page", out_pg, pg);
    chk(exp_a.size() == 0, tag, "writes left unmade", exp_a.size(), 0);
    exp_a.delete(); exp_d.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!wr_en && !frm_done && !frm_drop && !page_take, "R9", "outputs in reset",
        {wr_en, frm_done, frm_drop, page_take}, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!wr_en && !frm_done && !frm_drop, "R9", "outputs after reset", {wr_en, frm_done, frm_drop}, 0);

    run_frame(100, 0, 1, 0, 1, 2'd1, 0, "R1/R2/R4");
    run_frame(101, 0, 1, 0, 1, 2'd2, 0, "R5/R6");
    run_frame(101, 1, 1, 0, 1, 2'd3, 0, "R5");
    run_frame(10, 0, 1, 0, 1, 2'd0, 0, "R3/R4");
    run_frame(11, 0, 1, 0, 1, 2'd1, 0, "R3/R6");
    run_frame(63, 1, 1, 0, 1, 2'd2, 0, "R3");
    run_frame(64, 0, 1, 0, 1, 2'd3, 0, "R2");
    run_frame(1, 0, 1, 0, 1, 2'd2, 0, "R3 single-beat");
    run_frame(1519, 1, 1, 0, 1, 2'd0, 0, "R6 too-long");
    run_frame(1518, 0, 1, 0, 1, 2'd1, 0, "R6");
    run_frame(2038, 0, 1, 0, 1, 2'd3, 0, "R2 page-full");
    run_frame(2040, 0, 1, 0, 1, 2'd2, 0, "R8");
    run_frame(2047, 1, 1, 0, 1, 2'd1, 0, "R8 clamp");
    run_frame(80, 0, 0, 0, 1, 2'd1, 0, "R7 rx-off");
    run_frame(80, 0, 1, 1, 1, 2'd1, 0, "R7 soft-reset");
    run_frame(80, 0, 1, 0, 0, 2'd1, 0, "R7 no-page");
    run_frame(1, 0, 1, 0, 0, 2'd1, 0, "R7 single-beat");
    run_frame(70, 0, 1, 0, 1, 2'd0, 1, "R10 gaps");

    cur_tag = "R10";
    w0 = wr_total;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; in_valid = 1; in_sof = 0; in_eof = (i == 3); in_data = 8'(i + 9);
      rx_enable = 1; page_valid = 1;
    end
    @(posedge clk); #1; in_valid = 0; in_eof = 0;
    repeat (3) @(negedge clk);
    chk(wr_total == w0, "R10", "writes from stray idle beats", wr_total - w0, 0);
    run_frame(65, 0, 1, 0, 1, 2'd3, 0, "R10 after stray");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule